// File: doc/BRIEF.md
# Long-Word to Halfword Access Splitter

This block sits between a 32-bit host access port and a set of peripheral slots whose data path is either 16 or 32 bits wide. The host raises a request with an address, a write flag, four byte enables and write data, then holds them until the block returns a one-cycle acknowledge. The block runs one or two cycles on the shared slot bus and acknowledges only after the last one.

The host address carries a tag, a slot index, a width bit and a byte offset. An access in a slot's narrow window runs as halfword cycles: the lower halfword first, at the word-aligned offset, then the upper halfword. A per-slot option places the upper halfword at offset plus 2 or at the same offset again. An access in a slot's wide window runs as a single 32-bit cycle. No register write is needed to change width. Two more per-slot options exchange the bytes inside each halfword and exchange the two halfwords. Both apply in the same way to write data, byte enables and read data.

On a read, the halfword results are assembled into one 32-bit word and put back into host byte order before the acknowledge. Byte lanes the host did not enable are driven as zero on both buses.

Top module: `bus_narrower`

## Requirements
- R1: While reset is asserted, `h_ack`, `s_stb` and every bit of `s_sel` are low, and an access in progress is abandoned.
- R2: In a narrow window with auto-increment selected (`cfg_static` bit of the slot = 0), an access whose mapped enables cover both halfwords runs two slot cycles: first at the offset with bits 1:0 cleared, carrying mapped bytes 1:0, then at that offset plus 2, carrying mapped bytes 3:2.
- R3: With `cfg_static` set for the slot, the second cycle of a two-cycle narrow access uses the same offset as the first.
- R4: A narrow access whose mapped enables fall in one halfword only runs one slot cycle. The lower half goes to the aligned offset and the upper half to aligned plus 2. Narrow cycles use only lanes 15:0 and `s_be[1:0]`.
- R5: An access in a wide window (address bit OFF_W = 1) runs exactly one slot cycle with `s_wide` high, the full 32-bit lanes and all four mapped enables, at the aligned offset.
- R6: With the slot's byte-swap bit set, host byte i moves to lane i XOR 1. This holds for write data, enables and read data.
- R7: With the slot's word-swap bit set, host byte i moves to lane i XOR 2. With both bits set the two mappings combine, so byte i moves to lane i XOR 3.
- R8: On a narrow read, the lane 15:0 result of the lower cycle fills lanes 1:0 of the assembled word and that of the upper cycle fills lanes 3:2. Host byte i of `h_rdata` is assembled lane (i XOR swap), or zero if `h_be[i]` is low.
- R9: During a slot cycle every data byte whose `s_be` bit is low is zero, and `s_wdata` is zero on reads.
- R10: `h_ack` is high for exactly one cycle per request. It rises only after the slot acknowledge of the final cycle, and never while `s_stb` is high.
- R11: A request whose address tag differs from BASE_TAG, or whose byte enables are all zero, is acknowledged with no slot cycle, and its read data is zero.
- R12: While `s_stb` is high, exactly one `s_sel` bit is set, at the slot index taken from address bits OFF_W+1 upward; otherwise `s_sel` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req | input | 1 | Host request, held until acknowledged |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | HADDR_W | Host address: tag, slot, width bit, offset |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_ack | output | 1 | One-cycle completion pulse |
| h_rdata | output | 32 | Read data, valid with `h_ack` |
| cfg_static | input | NSLOT | Per-slot static second-cycle address |
| cfg_bswap | input | NSLOT | Per-slot byte swap within halfwords |
| cfg_wswap | input | NSLOT | Per-slot halfword swap |
| s_stb | output | 1 | Slot cycle active |
| s_sel | output | NSLOT | One-hot slot select |
| s_we | output | 1 | Slot cycle is a write |
| s_wide | output | 1 | Slot cycle is 32 bits wide |
| s_addr | output | OFF_W | Slot byte offset |
| s_be | output | 4 | Slot byte enables |
| s_wdata | output | 32 | Slot write data |
| s_rdata | input | 32 | Slot read data, sampled with `s_ack` |
| s_ack | input | 1 | Slot acknowledge, ends the current cycle |

## Verification
The assertions assume that the slot raises `s_ack` only while `s_stb` is high and for one cycle per slot cycle. They also assume the host holds its request fields steady until `h_ack` and drops `h_req` right after it. The bench's slot responder acknowledges one cycle after each strobe and drops its acknowledge right away. The bench host changes inputs only on falling edges and lowers the request in the cycle that shows `h_ack`. Each slot's configuration bits are set opposite to those of the other slots, so a design that reads the wrong slot's bit is caught.

// File: rtl/bnr_pkg.sv
package bnr_pkg;

   localparam int unsigned LANES  = 4;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned DATA_W = LANES * BYTE_W;
   localparam int unsigned HALF_W = DATA_W / 2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LO   = 2'd1,
      ST_HI   = 2'd2,
      ST_ACK  = 2'd3
   } seq_state_e;

   function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
      logic [DATA_W-1:0] m;
      for (int i = 0; i < int'(LANES); i++) begin
         m[i*BYTE_W +: BYTE_W] = {BYTE_W{be[i]}};
      end
      return m;
   endfunction

endpackage

// File: rtl/bnr_window_decode.sv
module bnr_window_decode #(
   parameter int unsigned NSLOT    = 4,
   parameter int unsigned HADDR_W  = 16,
   parameter int unsigned OFF_W    = 8,
   parameter int unsigned BASE_TAG = 'h14,
   localparam int unsigned SLOT_W  = $clog2(NSLOT),
   localparam int unsigned TAG_W   = HADDR_W - OFF_W - 1 - SLOT_W
) (
   input  logic [HADDR_W-1:0] h_addr,
   output logic               dec_hit,
   output logic               dec_wide,
   output logic [SLOT_W-1:0]  dec_slot,
   output logic [OFF_W-3:0]   dec_word
);

   logic [TAG_W-1:0] tag;
   logic             tag_ok;
   logic             slot_ok;
   logic             unused_low;

   assign tag        = h_addr[HADDR_W-1 -: TAG_W];
   assign tag_ok     = (tag == TAG_W'(BASE_TAG));
   assign dec_wide   = h_addr[OFF_W];
   assign dec_slot   = h_addr[OFF_W+1 +: SLOT_W];
   assign dec_word   = h_addr[OFF_W-1:2];
   assign unused_low = ^h_addr[1:0];

   generate
      if (NSLOT == (1 << SLOT_W)) begin : g_full_slots
         assign slot_ok = 1'b1;
      end else begin : g_part_slots
         assign slot_ok = (int'(dec_slot) < int'(NSLOT));
      end
   endgenerate

   assign dec_hit = tag_ok & slot_ok;

endmodule

// File: rtl/bnr_lane_perm.sv
module bnr_lane_perm #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned TOT_W = LANES * LANE_W
) (
   input  logic             swap_b,
   input  logic             swap_w,
   input  logic [TOT_W-1:0] din,
   output logic [TOT_W-1:0] dout
);

   generate
      if (LANES != 4) begin : g_bad_lanes
         $error("bnr_lane_perm: swap mapping needs exactly four lanes");
      end
   endgenerate

   int k;
   assign k = int'({swap_w, swap_b});

   always_comb begin
      for (int i = 0; i < int'(LANES); i++) begin
         dout[i*LANE_W +: LANE_W] = din[(i ^ k)*LANE_W +: LANE_W];
      end
   end

endmodule

// File: rtl/bnr_sequencer.sv
module bnr_sequencer
   import bnr_pkg::*;
#(
   parameter int unsigned NSLOT  = 4,
   parameter int unsigned OFF_W  = 8,
   localparam int unsigned SLOT_W = $clog2(NSLOT),
   localparam int unsigned WORD_W = OFF_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_req,
   input  logic              h_we,
   input  logic [LANES-1:0]  h_be,
   input  logic              dec_hit,
   input  logic              dec_wide,
   input  logic [SLOT_W-1:0] dec_slot,
   input  logic [WORD_W-1:0] dec_word,
   input  logic [LANES-1:0]  m_be,
   input  logic [DATA_W-1:0] m_wdata,
   input  logic              sel_static,
   input  logic              sel_bswap,
   input  logic              sel_wswap,
   input  logic              s_ack,
   input  logic [DATA_W-1:0] s_rdata,
   output logic              h_ack,
   output logic              s_stb,
   output logic [NSLOT-1:0]  s_sel,
   output logic              s_we,
   output logic              s_wide,
   output logic [OFF_W-1:0]  s_addr,
   output logic [LANES-1:0]  s_be,
   output logic [DATA_W-1:0] s_wdata,
   output logic [DATA_W-1:0] asm_data,
   output logic              lat_bswap,
   output logic              lat_wswap,
   output logic [LANES-1:0]  lat_hbe
);

   seq_state_e        state_q;
   logic              we_q;
   logic              wide_q;
   logic              static_q;
   logic [SLOT_W-1:0] slot_q;
   logic [WORD_W-1:0] word_q;
   logic [LANES-1:0]  mbe_q;
   logic [DATA_W-1:0] mdata_q;
   logic [DATA_W-1:0] asm_q;

   logic              lo_act;
   logic              hi_act;
   logic [OFF_W-1:0]  lo_addr;
   logic [OFF_W-1:0]  hi_addr;

   assign lo_act  = |mbe_q[1:0];
   assign hi_act  = |mbe_q[3:2];
   assign lo_addr = {word_q, 2'b00};
   assign hi_addr = (static_q && lo_act) ? lo_addr : lo_addr + OFF_W'(2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         we_q      <= 1'b0;
         wide_q    <= 1'b0;
         static_q  <= 1'b0;
         slot_q    <= '0;
         word_q    <= '0;
         mbe_q     <= '0;
         mdata_q   <= '0;
         asm_q     <= '0;
         lat_bswap <= 1'b0;
         lat_wswap <= 1'b0;
         lat_hbe   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (h_req) begin
                  we_q      <= h_we;
                  wide_q    <= dec_wide;
                  static_q  <= sel_static;
                  slot_q    <= dec_slot;
                  word_q    <= dec_word;
                  mbe_q     <= m_be;
                  mdata_q   <= m_wdata;
                  asm_q     <= '0;
                  lat_bswap <= sel_bswap;
                  lat_wswap <= sel_wswap;
                  lat_hbe   <= h_be;
                  if (!dec_hit || (m_be == '0)) begin
                     state_q <= ST_ACK;
                  end else if (dec_wide || (|m_be[1:0])) begin
                     state_q <= ST_LO;
                  end else begin
                     state_q <= ST_HI;
                  end
               end
            end
            ST_LO: begin
               if (s_ack) begin
                  if (wide_q) begin
                     asm_q   <= s_rdata;
                     state_q <= ST_ACK;
                  end else begin
                     asm_q[HALF_W-1:0] <= s_rdata[HALF_W-1:0];
                     state_q <= hi_act ? ST_HI : ST_ACK;
                  end
               end
            end
            ST_HI: begin
               if (s_ack) begin
                  asm_q[DATA_W-1:HALF_W] <= s_rdata[HALF_W-1:0];
                  state_q <= ST_ACK;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign h_ack    = (state_q == ST_ACK);
   assign s_stb    = (state_q == ST_LO) || (state_q == ST_HI);
   assign s_we     = s_stb & we_q;
   assign s_wide   = s_stb & wide_q;
   assign asm_data = asm_q;

   always_comb begin
      s_sel = '0;
      if (s_stb) begin
         s_sel[slot_q] = 1'b1;
      end
   end

   always_comb begin
      s_addr  = '0;
      s_be    = '0;
      s_wdata = '0;
      if (state_q == ST_LO) begin
         s_addr = lo_addr;
         if (wide_q) begin
            s_be    = mbe_q;
            s_wdata = mdata_q;
         end else begin
            s_be    = {2'b00, mbe_q[1:0]};
            s_wdata = {{HALF_W{1'b0}}, mdata_q[HALF_W-1:0]};
         end
      end else if (state_q == ST_HI) begin
         s_addr  = hi_addr;
         s_be    = {2'b00, mbe_q[3:2]};
         s_wdata = {{HALF_W{1'b0}}, mdata_q[DATA_W-1:HALF_W]};
      end
      if (!we_q) begin
         s_wdata = '0;
      end
   end

endmodule

// File: rtl/bus_narrower.sv
module bus_narrower
   import bnr_pkg::*;
#(
   parameter int unsigned NSLOT    = 4,
   parameter int unsigned HADDR_W  = 16,
   parameter int unsigned OFF_W    = 8,
   parameter int unsigned BASE_TAG = 'h14,
   localparam int unsigned SLOT_W  = $clog2(NSLOT),
   localparam int unsigned TAG_W   = HADDR_W - OFF_W - 1 - SLOT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               h_req,
   input  logic               h_we,
   input  logic [HADDR_W-1:0] h_addr,
   input  logic [3:0]         h_be,
   input  logic [31:0]        h_wdata,
   output logic               h_ack,
   output logic [31:0]        h_rdata,
   input  logic [NSLOT-1:0]   cfg_static,
   input  logic [NSLOT-1:0]   cfg_bswap,
   input  logic [NSLOT-1:0]   cfg_wswap,
   output logic               s_stb,
   output logic [NSLOT-1:0]   s_sel,
   output logic               s_we,
   output logic               s_wide,
   output logic [OFF_W-1:0]   s_addr,
   output logic [3:0]         s_be,
   output logic [31:0]        s_wdata,
   input  logic [31:0]        s_rdata,
   input  logic               s_ack
);

   generate
      if (NSLOT < 2) begin : g_bad_nslot
         $error("bus_narrower: NSLOT must be at least 2");
      end
      if (OFF_W < 3) begin : g_bad_off
         $error("bus_narrower: OFF_W must be at least 3");
      end
      if (HADDR_W < OFF_W + 2 + SLOT_W) begin : g_bad_tag
         $error("bus_narrower: HADDR_W leaves no room for a tag");
      end
      if (BASE_TAG >= (1 << TAG_W)) begin : g_bad_base
         $error("bus_narrower: BASE_TAG does not fit the tag field");
      end
   endgenerate

   logic              dec_hit;
   logic              dec_wide;
   logic [SLOT_W-1:0] dec_slot;
   logic [OFF_W-3:0]  dec_word;

   logic              sel_static;
   logic              sel_bswap;
   logic              sel_wswap;

   logic [DATA_W-1:0] perm_wdata;
   logic [LANES-1:0]  perm_be;
   logic [DATA_W-1:0] m_wdata;

   logic [DATA_W-1:0] asm_data;
   logic [DATA_W-1:0] perm_rdata;
   logic              lat_bswap;
   logic              lat_wswap;
   logic [LANES-1:0]  lat_hbe;

   bnr_window_decode #(
      .NSLOT    (NSLOT),
      .HADDR_W  (HADDR_W),
      .OFF_W    (OFF_W),
      .BASE_TAG (BASE_TAG)
   ) i_decode (
      .h_addr   (h_addr),
      .dec_hit  (dec_hit),
      .dec_wide (dec_wide),
      .dec_slot (dec_slot),
      .dec_word (dec_word)
   );

   assign sel_static = cfg_static[dec_slot];
   assign sel_bswap  = cfg_bswap[dec_slot];
   assign sel_wswap  = cfg_wswap[dec_slot];

   bnr_lane_perm #(.LANES(LANES), .LANE_W(BYTE_W)) i_wdata_perm (
      .swap_b (sel_bswap),
      .swap_w (sel_wswap),
      .din    (h_wdata),
      .dout   (perm_wdata)
   );

   bnr_lane_perm #(.LANES(LANES), .LANE_W(1)) i_be_perm (
      .swap_b (sel_bswap),
      .swap_w (sel_wswap),
      .din    (h_be),
      .dout   (perm_be)
   );

   assign m_wdata = perm_wdata & lane_mask(perm_be);

   bnr_sequencer #(
      .NSLOT (NSLOT),
      .OFF_W (OFF_W)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .h_req      (h_req),
      .h_we       (h_we),
      .h_be       (h_be),
      .dec_hit    (dec_hit),
      .dec_wide   (dec_wide),
      .dec_slot   (dec_slot),
      .dec_word   (dec_word),
      .m_be       (perm_be),
      .m_wdata    (m_wdata),
      .sel_static (sel_static),
      .sel_bswap  (sel_bswap),
      .sel_wswap  (sel_wswap),
      .s_ack      (s_ack),
      .s_rdata    (s_rdata),
      .h_ack      (h_ack),
      .s_stb      (s_stb),
      .s_sel      (s_sel),
      .s_we       (s_we),
      .s_wide     (s_wide),
      .s_addr     (s_addr),
      .s_be       (s_be),
      .s_wdata    (s_wdata),
      .asm_data   (asm_data),
      .lat_bswap  (lat_bswap),
      .lat_wswap  (lat_wswap),
      .lat_hbe    (lat_hbe)
   );

   bnr_lane_perm #(.LANES(LANES), .LANE_W(BYTE_W)) i_rdata_perm (
      .swap_b (lat_bswap),
      .swap_w (lat_wswap),
      .din    (asm_data),
      .dout   (perm_rdata)
   );

   assign h_rdata = perm_rdata & lane_mask(lat_hbe);

endmodule

// File: rtl/bnr_checker.sv
module bnr_checker
   import bnr_pkg::*;
#(
   parameter int unsigned NSLOT = 4,
   parameter int unsigned OFF_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             h_ack,
   input logic             s_stb,
   input logic [NSLOT-1:0] s_sel,
   input logic             s_wide,
   input logic             s_ack,
   input logic [OFF_W-1:0] s_addr,
   input logic [3:0]       s_be,
   input logic [31:0]      s_wdata
);

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) h_ack |=> !h_ack); // R10
   AST_ACK_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) h_ack |-> !s_stb); // R10
   AST_SEL_ONE: assert property (@(posedge clk) disable iff (!rst_n) s_stb |-> ($countones(s_sel) == 1)); // R12
   AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !s_stb |-> (s_sel == '0)); // R12
   AST_LANES_OFF: assert property (@(posedge clk) disable iff (!rst_n) s_stb |-> ((s_wdata & ~lane_mask(s_be)) == '0)); // R9
   AST_NARROW_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (s_stb && !s_wide) |-> (s_be[3:2] == 2'b00)); // R4
   AST_WIDE_ONCE: assert property (@(posedge clk) disable iff (!rst_n) (s_stb && s_ack && s_wide) |=> !s_stb); // R5
   AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (s_stb && !s_ack) |=> (s_stb && $stable(s_addr) && $stable(s_sel))); // R2

endmodule

bind bus_narrower bnr_checker #(.NSLOT(NSLOT), .OFF_W(OFF_W)) i_chk (.*);

// File: tb/test_bus_narrower.sv
`timescale 1ns/1ps
module test_bus_narrower;

   localparam int unsigned NSLOT   = 4;
   localparam int unsigned HADDR_W = 16;
   localparam int unsigned OFF_W   = 8;
   localparam logic [4:0]  TAG     = 5'h14;

   typedef struct packed {
      logic       we;
      logic       wide;
      logic [1:0] slot;
      logic [7:0] off;
      logic [3:0] be;
      logic [31:0] wd;
      logic       st;
      logic       bs;
      logic       ws;
      logic [1:0] ncyc;
   } vec_t;

   localparam int NVEC = 16;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 1'b0, 2'd0, 8'h10, 4'hF, 32'h1122_3344, 1'b0, 1'b0, 1'b0, 2'd2}, // R2
      '{1'b1, 1'b0, 2'd1, 8'h24, 4'hF, 32'hA1B2_C3D4, 1'b1, 1'b0, 1'b0, 2'd2}, // R3
      '{1'b1, 1'b0, 2'd2, 8'h08, 4'h3, 32'h5566_7788, 1'b0, 1'b0, 1'b0, 2'd1}, // R4 lower
      '{1'b1, 1'b0, 2'd3, 8'h0E, 4'hC, 32'h99AA_BBCC, 1'b0, 1'b0, 1'b0, 2'd1}, // R4 upper
      '{1'b1, 1'b1, 2'd1, 8'h40, 4'hF, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 2'd1}, // R5
      '{1'b1, 1'b0, 2'd0, 8'h30, 4'hF, 32'h0102_0304, 1'b0, 1'b1, 1'b0, 2'd2}, // R6
      '{1'b1, 1'b0, 2'd2, 8'h50, 4'h3, 32'h0A0B_0C0D, 1'b0, 1'b0, 1'b1, 2'd1}, // R7
      '{1'b1, 1'b1, 2'd3, 8'h60, 4'h1, 32'h0000_00E7, 1'b0, 1'b1, 1'b1, 2'd1}, // R6 R7
      '{1'b1, 1'b0, 2'd1, 8'h70, 4'h5, 32'hF1F2_F3F4, 1'b0, 1'b0, 1'b0, 2'd2}, // R9
      '{1'b0, 1'b0, 2'd2, 8'h80, 4'hF, 32'h0,         1'b0, 1'b0, 1'b0, 2'd2}, // R8
      '{1'b0, 1'b0, 2'd3, 8'h84, 4'hF, 32'h0,         1'b1, 1'b0, 1'b0, 2'd2}, // R8 R3
      '{1'b0, 1'b1, 2'd0, 8'h90, 4'hF, 32'h0,         1'b0, 1'b1, 1'b1, 2'd1}, // R5 R7
      '{1'b0, 1'b0, 2'd1, 8'hA0, 4'h2, 32'h0,         1'b0, 1'b0, 1'b0, 2'd1}, // R8 mask
      '{1'b1, 1'b0, 2'd0, 8'hB0, 4'h0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 2'd0}, // R11
      '{1'b0, 1'b0, 2'd2, 8'hC4, 4'hC, 32'h0,         1'b0, 1'b1, 1'b0, 2'd1}, // R6 read
      '{1'b0, 1'b0, 2'd0, 8'hD8, 4'h6, 32'h0,         1'b1, 1'b0, 1'b1, 2'd2}  // R7 R3 read
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               h_req = 1'b0;
   logic               h_we = 1'b0;
   logic [HADDR_W-1:0] h_addr = '0;
   logic [3:0]         h_be = '0;
   logic [31:0]        h_wdata = '0;
   logic               h_ack;
   logic [31:0]        h_rdata;
   logic [NSLOT-1:0]   cfg_static = '0;
   logic [NSLOT-1:0]   cfg_bswap = '0;
   logic [NSLOT-1:0]   cfg_wswap = '0;
   logic               s_stb;
   logic [NSLOT-1:0]   s_sel;
   logic               s_we;
   logic               s_wide;
   logic [OFF_W-1:0]   s_addr;
   logic [3:0]         s_be;
   logic [31:0]        s_wdata;
   logic [31:0]        s_rdata;
   logic               s_ack;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   bus_narrower #(
      .NSLOT(NSLOT), .HADDR_W(HADDR_W), .OFF_W(OFF_W), .BASE_TAG(32'(TAG))
   ) i_bus_narrower (
      .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
      .h_be(h_be), .h_wdata(h_wdata), .h_ack(h_ack), .h_rdata(h_rdata),
      .cfg_static(cfg_static), .cfg_bswap(cfg_bswap), .cfg_wswap(cfg_wswap),
      .s_stb(s_stb), .s_sel(s_sel), .s_we(s_we), .s_wide(s_wide), .s_addr(s_addr),
      .s_be(s_be), .s_wdata(s_wdata), .s_rdata(s_rdata), .s_ack(s_ack)
   );

   function automatic logic [15:0] f16(input logic [7:0] a);
      return {a ^ 8'hA5, a ^ 8'h11};
   endfunction

   function automatic logic [31:0] f32(input logic [7:0] a);
      return {a ^ 8'h3C, a ^ 8'h5A, f16(a)};
   endfunction

   // slot responder: acknowledge one cycle after each strobe
   assign s_rdata = s_wide ? f32(s_addr) : {16'hFFFF, f16(s_addr)};

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_ack <= 1'b0;
      else        s_ack <= s_stb && !s_ack;
   end

   // slot cycle log
   int          lg_n = 0;
   int          ack_n = 0;
   logic [7:0]  lg_addr [4];
   logic [3:0]  lg_be   [4];
   logic [31:0] lg_wd   [4];
   logic [3:0]  lg_sel  [4];
   logic        lg_wide [4];

   always @(posedge clk) begin
      if (rst_n && s_stb && s_ack && lg_n < 4) begin
         lg_addr[lg_n] = s_addr;
         lg_be[lg_n]   = s_be;
         lg_wd[lg_n]   = s_wdata;
         lg_sel[lg_n]  = s_sel;
         lg_wide[lg_n] = s_wide;
         lg_n = lg_n + 1;
      end
      if (rst_n && h_ack) ack_n = ack_n + 1;
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v, input logic [4:0] tag);
      int          k;
      int          en;
      logic [3:0]  mbe;
      logic [31:0] md;
      logic [7:0]  al;
      logic [7:0]  a2;
      logic [7:0]  ea [2];
      logic [3:0]  eb [2];
      logic [31:0] ed [2];
      logic [31:0] asmv;
      logic [31:0] erd;
      logic [31:0] rd;
      int          n_at_ack;
      int          waited;
      string       atag;
      logic        hit;

      hit = (tag == TAG);
      k = int'({v.ws, v.bs});
      for (int j = 0; j < 4; j++) begin
         mbe[j] = v.be[j ^ k];
         md[8*j +: 8] = v.be[j ^ k] ? v.wd[8*(j ^ k) +: 8] : 8'h00;
      end
      al = {v.off[7:2], 2'b00};
      en = 0;
      asmv = '0;
      for (int c = 0; c < 2; c++) begin
         ea[c] = '0; eb[c] = '0; ed[c] = '0;
      end
      if (hit && mbe != 4'h0) begin
         if (v.wide) begin
            ea[0] = al; eb[0] = mbe; ed[0] = v.we ? md : 32'h0;
            asmv = f32(al); en = 1;
         end else begin
            if (|mbe[1:0]) begin
               ea[en] = al; eb[en] = {2'b00, mbe[1:0]};
               ed[en] = v.we ? {16'h0, md[15:0]} : 32'h0;
               asmv[15:0] = f16(al); en = en + 1;
            end
            if (|mbe[3:2]) begin
               a2 = (v.st && |mbe[1:0]) ? al : al + 8'd2;
               ea[en] = a2; eb[en] = {2'b00, mbe[3:2]};
               ed[en] = v.we ? {16'h0, md[31:16]} : 32'h0;
               asmv[31:16] = f16(a2); en = en + 1;
            end
         end
      end
      for (int i = 0; i < 4; i++) begin
         erd[8*i +: 8] = v.be[i] ? asmv[8*(i ^ k) +: 8] : 8'h00;
      end
      if (!hit) erd = '0;

      @(negedge clk);
      lg_n = 0;
      ack_n = 0;
      cfg_static = v.st ? (4'b1 << v.slot) : ~(4'b1 << v.slot);
      cfg_bswap  = v.bs ? (4'b1 << v.slot) : ~(4'b1 << v.slot);
      cfg_wswap  = v.ws ? (4'b1 << v.slot) : ~(4'b1 << v.slot);
      h_we    = v.we;
      h_addr  = {tag, v.slot, v.wide, v.off};
      h_be    = v.be;
      h_wdata = v.wd;
      h_req   = 1'b1;
      waited  = 0;
      do begin
         @(negedge clk);
         waited++;
      end while (!h_ack && waited < 40);
      rd = h_rdata;
      n_at_ack = lg_n;
      h_req = 1'b0;
      chk("R10 slot cycles done at ack", 32'(n_at_ack), 32'(hit ? v.ncyc : 2'd0));
      chk("R10 ack seen", 32'(h_ack), 32'd1);
      atag = v.wide ? "R5 address" : (v.st ? "R3 address" : "R2 address");
      for (int c = 0; c < en && c < n_at_ack; c++) begin
         chk(atag, 32'(lg_addr[c]), 32'(ea[c]));
         chk("R9 byte enables", 32'(lg_be[c]), 32'(eb[c]));
         chk("R9 write lanes", lg_wd[c], ed[c]);
         chk("R12 slot select", 32'(lg_sel[c]), 32'(4'b1 << v.slot));
         chk("R5 width flag", 32'(lg_wide[c]), 32'(v.wide));
      end
      if (!v.we) chk("R8 read data", rd, erd);
      repeat (3) @(negedge clk);
      chk("R10 one ack per request", 32'(ack_n), 32'd1);
      chk("R10 no cycle after ack", 32'(lg_n), 32'(n_at_ack));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset ack", 32'(h_ack), 32'd0);
      chk("R1 reset strobe", 32'(s_stb), 32'd0);
      chk("R1 reset select", 32'(s_sel), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int n = 0; n < NVEC; n++) begin
         run_vec(VECS[n], TAG);
      end

      // R11: tag outside the window, read and write
      run_vec('{1'b0, 1'b0, 2'd1, 8'h20, 4'hF, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0}, TAG ^ 5'h01);
      run_vec('{1'b1, 1'b1, 2'd2, 8'h20, 4'hF, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 2'd0}, 5'h00);

      // R1: reset during a slot cycle abandons it
      @(negedge clk);
      h_we = 1'b1; h_addr = {TAG, 2'd3, 1'b0, 8'h44}; h_be = 4'hF; h_wdata = 32'hCAFE_F00D;
      cfg_static = '0; cfg_bswap = '0; cfg_wswap = '0;
      h_req = 1'b1;
      @(negedge clk);
      chk("R1 strobe before reset", 32'(s_stb), 32'd1);
      rst_n = 1'b0;
      #1;
      chk("R1 strobe drops in reset", 32'(s_stb), 32'd0);
      chk("R1 select drops in reset", 32'(s_sel), 32'd0);
      chk("R1 ack low in reset", 32'(h_ack), 32'd0);
      h_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle after reset", 32'(s_stb), 32'd0);

      // normal access after reset recovery
      run_vec(VECS[0], TAG);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      $display("FAIL R10 watchdog expired: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
      $finish;
   end

endmodule